// File: doc/BRIEF.md
# Immediate-Operand ALU Group Executor

This block performs one 32-bit arithmetic or logic operation between a destination operand and an immediate value each time it is started. The operation comes either from a three-bit selector held in bits [5:3] of the addressing byte that follows a group opcode, or, for the short accumulator forms, from the opcode byte alone. A surrounding execution pipeline supplies the current destination value and the immediate. It then takes the registered result, a write-enable and the sign, zero and overflow flags one cycle later.

Compare computes the difference and updates the flags, but it never asserts the write-enable. A selector value that names no supported operation, or an unsupported short opcode, raises an illegal-operation pulse. The surrounding control uses that pulse to abort execution. Fetch, address generation, memory access and the carry flag are handled elsewhere.

Top module: `imm_alu_exec`

## Requirements
- R1: In long form (`short_form_i` = 0), the operation is `modrm_i[5:3]`: 0 add, 1 OR, 4 AND, 5 subtract, 6 XOR, 7 compare. The other bits of `modrm_i` have no effect on the result.
- R2: Add produces destination plus immediate modulo 2^32 and asserts `wr_en_o`. For example, 1 + 0x0D0C0B0A gives 0x0D0C0B0B.
- R3: Subtract produces destination minus immediate modulo 2^32 and asserts `wr_en_o`.
- R4: AND, OR and XOR produce the bitwise result, assert `wr_en_o` and clear the overflow flag. For example, 0xD0C0B0A0 OR 0x0D0C0B0A gives 0xDDCCBBAA.
- R5: Compare places destination minus immediate on `result_o` and updates the flags, with `wr_en_o` held low.
- R6: After every legal operation, `sign_o` equals bit 31 of the result and `zero_o` is set exactly when the result is zero.
- R7: For add, subtract and compare, `ovf_o` is set exactly when the full-precision signed result differs from the 32-bit signed result.
- R8: Selector values 2 and 3 pulse `illegal_o` with `done_o`. They keep `wr_en_o` low and leave `result_o` and all flags unchanged.
- R9: In short form (`short_form_i` = 1), `modrm_i` is ignored and `opcode_i` selects the operation: 0x2D subtract, 0x25 AND, 0x0D OR, 0x35 XOR, 0x3D compare. Any other opcode is illegal, as in R8.
- R10: `done_o` pulses high for exactly the one cycle after a cycle with `start_i` high, and stays low otherwise. `wr_en_o` and `illegal_o` are only high together with `done_o`. Without `start_i`, `result_o` and the flags hold their values.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one operation this cycle |
| short_form_i | input | 1 | 1: operation taken from opcode_i; 0: from modrm_i[5:3] |
| opcode_i | input | 8 | Short-form opcode byte |
| modrm_i | input | 8 | Addressing byte carrying the selector |
| dst_i | input | DATA_W | Destination operand value |
| imm_i | input | DATA_W | Immediate operand |
| done_o | output | 1 | Result valid pulse |
| result_o | output | DATA_W | Registered result (difference for compare) |
| wr_en_o | output | 1 | Write the result back to the destination |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Signed overflow flag |
| illegal_o | output | 1 | Unsupported operation pulse |

## Verification
The bench builds the block with the default DATA_W of 32, so the overflow boundaries sit at 0x7FFFFFFF and 0x80000000. Random operands are biased toward those two values, toward zero and toward operand equality. This brings the signed-overflow, zero-result and compare-equal corners into reach alongside fully random values. Random addressing bytes also cover every selector value, including the illegal ones, and vary the bits outside [5:3].

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_OR  = 3'd1,
    OP_AND = 3'd4,
    OP_SUB = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  localparam logic [7:0] SHORT_SUB = 8'h2D;
  localparam logic [7:0] SHORT_AND = 8'h25;
  localparam logic [7:0] SHORT_OR  = 8'h0D;
  localparam logic [7:0] SHORT_XOR = 8'h35;
  localparam logic [7:0] SHORT_CMP = 8'h3D;

  function automatic logic is_logic_op(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/imm_alu_decode.sv
module imm_alu_decode
  import imm_alu_pkg::*;
(
  input  logic       short_form_i,
  input  logic [7:0] opcode_i,
  input  logic [7:0] modrm_i,
  output alu_op_e    op_o,
  output logic       legal_o
);

  logic [2:0] sel;

  assign sel = modrm_i[5:3];

  always_comb begin
    op_o    = OP_ADD;
    legal_o = 1'b0;
    if (short_form_i) begin
      legal_o = 1'b1;
      unique case (opcode_i)
        SHORT_SUB: op_o = OP_SUB;
        SHORT_AND: op_o = OP_AND;
        SHORT_OR:  op_o = OP_OR;
        SHORT_XOR: op_o = OP_XOR;
        SHORT_CMP: op_o = OP_CMP;
        default:   legal_o = 1'b0;
      endcase
    end else begin
      legal_o = 1'b1;
      case (sel)
        3'd0:    op_o = OP_ADD;
        3'd1:    op_o = OP_OR;
        3'd4:    op_o = OP_AND;
        3'd5:    op_o = OP_SUB;
        3'd6:    op_o = OP_XOR;
        3'd7:    op_o = OP_CMP;
        default: legal_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/imm_alu_arith.sv
module imm_alu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
    sum_o = wide[DATA_W-1:0];
    ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end

endmodule

// File: rtl/imm_alu_logic.sv
module imm_alu_logic
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              short_form_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        modrm_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              sign_o,
  output logic              zero_o,
  output logic              ovf_o,
  output logic              illegal_o
);

  localparam int MSB = DATA_W - 1;

  alu_op_e           dec_op;
  logic              dec_legal;
  logic [DATA_W-1:0] arith_res;
  logic              arith_ovf;
  logic [DATA_W-1:0] logic_res;
  logic              use_sub;

  logic              done_d, wr_d, sign_d, zero_d, ovf_d, illegal_d;
  logic [DATA_W-1:0] result_d;
  logic [DATA_W-1:0] op_res;

  imm_alu_decode u_decode (
    .short_form_i (short_form_i),
    .opcode_i     (opcode_i),
    .modrm_i      (modrm_i),
    .op_o         (dec_op),
    .legal_o      (dec_legal)
  );

  assign use_sub = (dec_op == OP_SUB) || (dec_op == OP_CMP);

  imm_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i   (dst_i),
    .b_i   (imm_i),
    .sub_i (use_sub),
    .sum_o (arith_res),
    .ovf_o (arith_ovf)
  );

  imm_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (dst_i),
    .b_i   (imm_i),
    .op_i  (dec_op),
    .res_o (logic_res)
  );

  // next-state
  always_comb begin
    done_d    = 1'b0;
    wr_d      = 1'b0;
    illegal_d = 1'b0;
    result_d  = result_o;
    sign_d    = sign_o;
    zero_d    = zero_o;
    ovf_d     = ovf_o;
    op_res    = is_logic_op(dec_op) ? logic_res : arith_res;
    if (start_i) begin
      done_d    = 1'b1;
      illegal_d = !dec_legal;
      if (dec_legal) begin
        wr_d     = (dec_op != OP_CMP);
        result_d = op_res;
        sign_d   = op_res[MSB];
        zero_d   = (op_res == '0);
        ovf_d    = is_logic_op(dec_op) ? 1'b0 : arith_ovf;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      sign_o    <= 1'b0;
      zero_o    <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      done_o    <= done_d;
      wr_en_o   <= wr_d;
      illegal_o <= illegal_d;
      result_o  <= result_d;
      sign_o    <= sign_d;
      zero_o    <= zero_d;
      ovf_o     <= ovf_d;
    end
  end

  // R10: done follows start by one cycle, and only then
  a_r10_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(result_o) && $stable(sign_o) && $stable(zero_o) && $stable(ovf_o));
  a_r10_wr_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o);
  // R8: illegal never writes and leaves flags untouched
  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> done_o && !wr_en_o);
  a_r8_illegal_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(result_o) && $stable(sign_o) && $stable(zero_o) && $stable(ovf_o));
  // R5: compare never requests a write
  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && dec_legal && dec_op == OP_CMP) |=> !wr_en_o);
  // R4: logic operations leave overflow clear
  a_r4_logic_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && dec_legal && is_logic_op(dec_op)) |=> !ovf_o);
  // R6: zero flag agrees with the result after a legal operation
  a_r6_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !illegal_o) |-> (zero_o == (result_o == '0)));

endmodule

// File: tb/test_imm_alu_exec.sv
`timescale 1ns/1ps
module test_imm_alu_exec;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         short_form_i;
  logic [7:0]   opcode_i;
  logic [7:0]   modrm_i;
  logic [W-1:0] dst_i;
  logic [W-1:0] imm_i;
  logic         done_o, wr_en_o, sign_o, zero_o, ovf_o, illegal_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic         legal;
    logic         wr;
    logic [W-1:0] res;
    logic         s;
    logic         z;
    logic         o;
  } exp_t;

  // state the model expects the block to hold
  logic [W-1:0] m_res;
  logic         m_s, m_z, m_o;

  imm_alu_exec #(.DATA_W(W)) i_imm_alu_exec (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_form_i(short_form_i),
    .opcode_i(opcode_i), .modrm_i(modrm_i), .dst_i(dst_i), .imm_i(imm_i),
    .done_o(done_o), .result_o(result_o), .wr_en_o(wr_en_o), .sign_o(sign_o),
    .zero_o(zero_o), .ovf_o(ovf_o), .illegal_o(illegal_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic exp_t model(input logic sf, input logic [7:0] opc,
                                 input logic [7:0] mrm, input logic [W-1:0] a,
                                 input logic [W-1:0] b);
    exp_t e;
    int code;
    longint sa, sb, full;
    e = '0;
    code = -1;
    if (sf) begin
      case (opc)
        8'h2D: code = 5;
        8'h25: code = 4;
        8'h0D: code = 1;
        8'h35: code = 6;
        8'h3D: code = 7;
        default: code = -1;
      endcase
    end else begin
      code = int'(mrm[5:3]);
      if (code == 2 || code == 3) code = -1;
    end
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    e.legal = (code >= 0);
    case (code)
      0: begin full = sa + sb; e.res = a + b; end
      5, 7: begin full = sa - sb; e.res = a - b; end
      1: begin full = 0; e.res = a | b; end
      4: begin full = 0; e.res = a & b; end
      6: begin full = 0; e.res = a ^ b; end
      default: begin full = 0; e.res = '0; end
    endcase
    e.wr = e.legal && (code != 7);
    e.s  = e.res[W-1];
    e.z  = (e.res == 0);
    e.o  = (code == 0 || code == 5 || code == 7) ? (full != longint'($signed(e.res))) : 1'b0;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic sf, input logic [7:0] opc, input logic [7:0] mrm,
                        input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    exp_t e;
    e = model(sf, opc, mrm, a, b);
    @(negedge clk);
    start_i = 1'b1; short_form_i = sf; opcode_i = opc; modrm_i = mrm;
    dst_i = a; imm_i = b;
    @(negedge clk);
    start_i = 1'b0;
    opcode_i = 8'h00; modrm_i = 8'h00; dst_i = $urandom; imm_i = $urandom;
    if (e.legal) begin
      m_res = e.res; m_s = e.s; m_z = e.z; m_o = e.o;
    end
    chk(done_o == 1'b1, "R10", "done", W'(done_o), W'(1));
    chk(illegal_o == !e.legal, e.legal ? req : "R8", "illegal", W'(illegal_o), W'(!e.legal));
    chk(wr_en_o == e.wr, e.legal ? req : "R8", "wr_en", W'(wr_en_o), W'(e.wr));
    chk(result_o == m_res, req, "result", result_o, m_res);
    chk({sign_o, zero_o} == {m_s, m_z}, e.legal ? "R6" : "R8", "sign/zero",
        W'({sign_o, zero_o}), W'({m_s, m_z}));
    chk(ovf_o == m_o, e.legal ? "R7" : "R8", "ovf", W'(ovf_o), W'(m_o));
  endtask

  function automatic logic [W-1:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h0;
      3: return 32'hFFFF_FFFF;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; start_i = 1'b0; short_form_i = 1'b0;
    opcode_i = 8'h00; modrm_i = 8'h00; dst_i = '0; imm_i = '0;
    m_res = '0; m_s = 0; m_z = 0; m_o = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({done_o, wr_en_o, sign_o, zero_o, ovf_o, illegal_o} == 6'b0, "R11", "flags",
        W'({done_o, wr_en_o, sign_o, zero_o, ovf_o, illegal_o}), '0);
    chk(result_o == '0, "R11", "result", result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed
    run_op(0, 8'h81, 8'hC3, 32'h1, 32'h0D0C0B0A, "R2");
    run_op(0, 8'h81, 8'h03, 32'h7FFF_FFFF, 32'h1, "R2");
    run_op(0, 8'h81, 8'hCB, 32'hD0C0B0A0, 32'h0D0C0B0A, "R4");
    run_op(0, 8'h81, 8'hE3, 32'hFF, 32'h0D0C0B0A, "R4");
    run_op(0, 8'h81, 8'hF3, 32'hD0C0B0A0, 32'h0D0C0B0A, "R4");
    run_op(0, 8'h81, 8'hEB, 32'd10, 32'd1, "R3");
    run_op(0, 8'h81, 8'h2B, 32'h8000_0000, 32'h1, "R3");
    run_op(0, 8'h81, 8'hFB, 32'h0D0C0B0A, 32'h0D0C0B07, "R5");
    run_op(0, 8'h81, 8'hFB, 32'h0D0C0B07, 32'h0D0C0B0A, "R5");
    run_op(0, 8'h81, 8'h3B, 32'h0D0C0B0A, 32'h0D0C0B0A, "R5");
    run_op(0, 8'h81, 8'hD3, 32'h5, 32'h5, "R8");
    run_op(0, 8'h81, 8'h1B, 32'h5, 32'h5, "R8");
    run_op(1, 8'h2D, 8'h00, 32'h0D0C0BAA, 32'h0D0C0B0A, "R9");
    run_op(1, 8'h25, 8'hC0, 32'hFF, 32'h0D0C0B0A, "R9");
    run_op(1, 8'h0D, 8'hFB, 32'hD0C0B0A0, 32'h0D0C0B0A, "R9");
    run_op(1, 8'h35, 8'h13, 32'hDDCCB0A0, 32'h0D0C0B0A, "R9");
    run_op(1, 8'h3D, 8'h00, 32'h1, 32'h2, "R9");
    run_op(1, 8'h05, 8'hC3, 32'h1, 32'h2, "R9");
    // R1: bits outside [5:3] do not matter
    run_op(0, 8'h81, 8'h07, 32'h10, 32'h20, "R1");
    run_op(0, 8'h81, 8'hC7, 32'h10, 32'h20, "R1");

    // R10: idle cycles hold outputs and keep done low
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!done_o && !wr_en_o && !illegal_o, "R10", "idle pulses",
          W'({done_o, wr_en_o, illegal_o}), '0);
      chk(result_o == m_res, "R10", "held result", result_o, m_res);
    end

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic sf;
      logic [7:0] opc;
      logic [W-1:0] a, b;
      sf = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 5))
        0: opc = 8'h2D; 1: opc = 8'h25; 2: opc = 8'h0D;
        3: opc = 8'h35; 4: opc = 8'h3D; default: opc = 8'($urandom);
      endcase
      a = pick_val();
      b = ($urandom_range(0, 4) == 0) ? a : pick_val();
      run_op(sf, opc, 8'($urandom), a, b, sf ? "R9" : "R1");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule